// File: doc/BRIEF.md
# Alignment-Aware Memory Copy Engine

This block copies a run of bytes from one region of a memory to another. A caller supplies a source byte address, a destination byte address and a byte count with a one-cycle start pulse. The engine then drives a single-port synchronous memory through a valid/ready request port, one access per cycle at most, and raises a one-cycle done pulse when the last byte has been written.

The engine picks its transfer pattern at start. Whole-word transfers are used only when both pointers sit on a word boundary and the count covers at least one burst of four words. In that case it moves four-word bursts (four reads into a local buffer, then four writes) while a burst's worth of bytes remains, then single words, then a byte tail. If either pointer is misaligned or the count is short, every byte is moved on its own. Each transfer unit reads before it writes, and both pointers step by the unit size.

The memory answers a read with data in the cycle after the read is accepted and holds that data until the next accepted read. Source and destination regions are assumed not to overlap.

Top module: `mem_copy_engine`

## Requirements
- R1: A start with a byte count of zero issues no memory request and pulses done two cycles after start is sampled.
- R2: When the low two bits of source OR destination are nonzero, or the count is below 16, every write is a byte write: memByteEn has only bit dst[1:0] set and memWdata holds the source byte in all four lanes.
- R3: When both pointers are word aligned and the count is at least 16, the engine repeats bursts of four reads of consecutive words followed by four writes with memByteEn = 4'b1111 while at least 16 bytes remain.
- R4: After the bursts of an aligned copy, single-word units (one read, then one full-word write) are used while at least 4 bytes remain.
- R5: Bytes left over after the word phases are moved as byte units, one read then one single-lane write each.
- R6: After done, every destination byte equals the source byte at the same offset, bytes outside the destination range are unchanged, and no word access uses an address with nonzero low bits.
- R7: busy is high from the cycle after start is accepted until done; done is high for exactly one cycle.
- R8: A start pulse while busy is ignored: the running copy finishes unchanged and no second done follows.
- R9: A request is held with the same address, direction, data and byte enables until memReady accepts it; reads carry memByteEn = 4'b0000 and a word-aligned memAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle |
| srcAddr | input | ADDR_W | Source byte address |
| dstAddr | input | ADDR_W | Destination byte address |
| byteLen | input | LEN_W | Number of bytes to copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memWrite | output | 1 | Request is a write (else read) |
| memAddr | output | ADDR_W | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memByteEn | output | 4 | Write lane enables, zero on reads |
| memRdata | input | 32 | Read data, valid the cycle after an accepted read |

## Verification
Assertions watch, on every cycle, that requests hold steady under back-pressure, that word accesses only use aligned pointers, that the remaining count never steps below zero, and that done is a single-cycle pulse raised only with nothing left to move. The choice of pattern for a given alignment and length, the exact order of burst, word and byte units, and the final contents of memory can only be shown by the bench's scenarios, which compare the recorded access trace and the destination bytes against models built from the requirements, with random back-pressure and a start pulse injected mid-copy.

// File: rtl/mcopy_pkg.sv
package mcopy_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W = 8 * WORD_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } ctrl_state_e;

  typedef struct packed {
    logic load;
    logic rdFire;
    logic wrFire;
    logic byteUnit;
  } dp_strobe_t;
endpackage

// File: rtl/mcopy_ctrl.sv
module mcopy_ctrl
  import mcopy_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int BURST_WORDS = 4,
  localparam int IDX_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1,
  localparam int BURST_BYTES = BURST_WORDS * WORD_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       startSrcLow,
  input  logic [1:0]       startDstLow,
  input  logic [LEN_W-1:0] startLen,
  input  logic [LEN_W-1:0] remaining,
  input  logic             memReady,
  output dp_strobe_t       strobe,
  output logic [IDX_W-1:0] idx,
  output logic             memValid,
  output logic             memWrite,
  output logic             busy,
  output logic             done
);
  ctrl_state_e state;
  logic wordMode;
  logic unitIsByte;
  logic [IDX_W:0] unitCount;
  logic accept;
  logic lastIdx;

  assign memValid = (state == ST_READ) || (state == ST_WRITE);
  assign memWrite = (state == ST_WRITE);
  assign accept   = memValid && memReady;
  assign lastIdx  = ({1'b0, idx} == (unitCount - 1'b1));
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

  always_comb begin
    strobe.load     = (state == ST_IDLE) && start;
    strobe.rdFire   = (state == ST_READ) && accept;
    strobe.wrFire   = (state == ST_WRITE) && accept;
    strobe.byteUnit = unitIsByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wordMode   <= 1'b0;
      unitIsByte <= 1'b1;
      unitCount  <= (IDX_W+1)'(1);
      idx        <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          wordMode <= ((startSrcLow | startDstLow) == 2'b00) &&
                      (startLen >= LEN_W'(BURST_BYTES));
          state    <= ST_PICK;
        end
        ST_PICK: begin
          idx <= '0;
          if (remaining == '0) begin
            state <= ST_DONE;
          end else begin
            state <= ST_READ;
            if (wordMode && remaining >= LEN_W'(BURST_BYTES)) begin
              unitCount  <= (IDX_W+1)'(BURST_WORDS);
              unitIsByte <= 1'b0;
            end else if (wordMode && remaining >= LEN_W'(WORD_BYTES)) begin
              unitCount  <= (IDX_W+1)'(1);
              unitIsByte <= 1'b0;
            end else begin
              unitCount  <= (IDX_W+1)'(1);
              unitIsByte <= 1'b1;
            end
          end
        end
        ST_READ: if (accept) begin
          if (lastIdx) begin
            idx   <= '0;
            state <= ST_WRITE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_WRITE: if (accept) begin
          if (lastIdx) begin
            idx   <= '0;
            state <= ST_PICK;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remaining == '0));

  // R1
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PICK && remaining == '0) |=> (done && !memValid));

  // R3
  burst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !unitIsByte) |-> wordMode);
endmodule

// File: rtl/mcopy_datapath.sv
module mcopy_datapath
  import mcopy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 16,
  parameter int BURST_WORDS = 4,
  localparam int IDX_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_strobe_t        strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic [LEN_W-1:0]  startLen,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [3:0]        memByteEn,
  output logic [LEN_W-1:0]  remaining
);
  logic [ADDR_W-1:0] srcPtr, dstPtr;
  logic [ADDR_W-1:0] ptrStep;
  logic [LEN_W-1:0]  lenStep;
  logic [DATA_W-1:0] wordBuf [BURST_WORDS];
  logic              capValid;
  logic [IDX_W-1:0]  capIdx;
  logic [1:0]        srcLane;
  logic [DATA_W-1:0] curWord;
  logic [7:0]        byteVal;
  logic [ADDR_W-1:0] selPtr;

  assign ptrStep = strobe.byteUnit ? ADDR_W'(1) : ADDR_W'(WORD_BYTES);
  assign lenStep = strobe.byteUnit ? LEN_W'(1) : LEN_W'(WORD_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcPtr    <= '0;
      dstPtr    <= '0;
      remaining <= '0;
      capValid  <= 1'b0;
      capIdx    <= '0;
      srcLane   <= '0;
    end else begin
      capValid <= strobe.rdFire;
      if (strobe.load) begin
        srcPtr    <= startSrc;
        dstPtr    <= startDst;
        remaining <= startLen;
      end
      if (strobe.rdFire) begin
        srcPtr  <= srcPtr + ptrStep;
        capIdx  <= idx;
        srcLane <= srcPtr[1:0];
      end
      if (strobe.wrFire) begin
        dstPtr    <= dstPtr + ptrStep;
        remaining <= remaining - lenStep;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (capValid) wordBuf[capIdx] <= memRdata;
  end

  assign curWord  = (capValid && capIdx == idx) ? memRdata : wordBuf[idx];
  assign byteVal  = curWord[8*srcLane +: 8];
  assign selPtr   = memWrite ? dstPtr : srcPtr;
  assign memAddr  = {selPtr[ADDR_W-1:2], 2'b00};
  assign memWdata = strobe.byteUnit ? {WORD_BYTES{byteVal}} : curWord;

  always_comb begin
    if (!memWrite)            memByteEn = 4'b0000;
    else if (strobe.byteUnit) memByteEn = 4'b0001 << dstPtr[1:0];
    else                      memByteEn = 4'b1111;
  end

  // R6
  word_src_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.rdFire && !strobe.byteUnit) |-> (srcPtr[1:0] == 2'b00));

  // R6
  word_dst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrFire && !strobe.byteUnit) |-> (dstPtr[1:0] == 2'b00));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrFire |-> (remaining >= lenStep));
endmodule

// File: rtl/mem_copy_engine.sv
module mem_copy_engine
  import mcopy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 16,
  parameter int BURST_WORDS = 4,
  localparam int IDX_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [LEN_W-1:0]  byteLen,
  output logic              busy,
  output logic              done,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memByteEn,
  input  logic [31:0]       memRdata
);
  dp_strobe_t       strobe;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] remaining;

  mcopy_ctrl #(.LEN_W(LEN_W), .BURST_WORDS(BURST_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .startSrcLow(srcAddr[1:0]), .startDstLow(dstAddr[1:0]),
    .startLen(byteLen), .remaining(remaining), .memReady(memReady),
    .strobe(strobe), .idx(idx), .memValid(memValid), .memWrite(memWrite),
    .busy(busy), .done(done)
  );

  mcopy_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_WORDS(BURST_WORDS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .idx(idx), .memWrite(memWrite),
    .startSrc(srcAddr), .startDst(dstAddr), .startLen(byteLen),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memByteEn(memByteEn), .remaining(remaining)
  );

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)
                                 && $stable(memByteEn) && $stable(memWdata)));

  // R9
  read_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memWrite) |-> (memByteEn == 4'b0000));

  // R2
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && memWrite) |-> ($onehot(memByteEn) || memByteEn == 4'b1111));
endmodule

// File: tb/tb_mem_copy_engine.sv
module tb_mem_copy_engine;
  localparam int MEM_BYTES = 1024;
  localparam int MAXOPS = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] srcAddr = '0, dstAddr = '0, byteLen = '0;
  logic busy, done, memValid, memWrite;
  logic memReady = 1'b1;
  logic [15:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic [3:0] memByteEn;

  always #4 clk = ~clk;

  mem_copy_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .byteLen(byteLen), .busy(busy), .done(done), .memValid(memValid),
    .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memByteEn(memByteEn), .memRdata(memRdata)
  );

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] refMem [MEM_BYTES];
  logic       opW [MAXOPS];
  logic [15:0] opA [MAXOPS];
  logic [3:0] opBe [MAXOPS];
  logic       expW [MAXOPS];
  logic [15:0] expA [MAXOPS];
  logic [3:0] expBe [MAXOPS];
  int opCount = 0, expCount = 0, doneCount = 0, holdViol = 0;
  int checks = 0, errors = 0;
  logic prevPending = 1'b0;
  logic [15:0] prevAddr = '0;

  // memory model and access monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (prevPending && !(memValid && memAddr == prevAddr)) holdViol++;
      prevPending <= memValid && !memReady;
      prevAddr <= memAddr;
      if (done) doneCount++;
      if (memValid && memReady) begin
        if (opCount < MAXOPS) begin
          opW[opCount] = memWrite; opA[opCount] = memAddr; opBe[opCount] = memByteEn;
        end
        opCount++;
        if (memWrite) begin
          for (int k = 0; k < 4; k++)
            if (memByteEn[k]) mem[int'(memAddr[9:0]) + k] <= memWdata[8*k +: 8];
        end else begin
          memRdata <= {mem[int'(memAddr[9:0]) + 3], mem[int'(memAddr[9:0]) + 2],
                       mem[int'(memAddr[9:0]) + 1], mem[int'(memAddr[9:0])]};
        end
      end
    end
  end

  always @(negedge clk) memReady = ($urandom_range(3) != 0);

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic buildExpected(input int s, input int d, input int n);
    bit wm, bu;
    int rem, words;
    expCount = 0;
    wm = (((s | d) & 3) == 0) && (n >= 16);
    rem = n;
    while (rem > 0) begin
      if (wm && rem >= 16) begin words = 4; bu = 0; end
      else if (wm && rem >= 4) begin words = 1; bu = 0; end
      else begin words = 1; bu = 1; end
      for (int k = 0; k < words; k++) begin
        expW[expCount] = 0; expA[expCount] = 16'(s & ~3); expBe[expCount] = 4'b0000;
        expCount++; s += bu ? 1 : 4;
      end
      for (int k = 0; k < words; k++) begin
        expW[expCount] = 1; expA[expCount] = 16'(d & ~3);
        expBe[expCount] = bu ? 4'(1 << (d & 3)) : 4'b1111;
        expCount++; d += bu ? 1 : 4; rem -= bu ? 1 : 4;
      end
    end
  endtask

  task automatic runCase(input int s, input int d, input int n, input bit poke);
    int wait_cycles, mism, firstBad, wordWr, byteWr, expWordWr, expByteWr, doneBefore;
    bit wm;
    string tag;
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem[i] = 8'($urandom); refMem[i] = mem[i];
    end
    for (int i = 0; i < n; i++) refMem[d + i] = mem[s + i];
    buildExpected(s, d, n);
    wm = (((s | d) & 3) == 0) && (n >= 16);
    opCount = 0; doneBefore = doneCount;
    @(negedge clk);
    srcAddr = 16'(s); dstAddr = 16'(d); byteLen = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
    wait_cycles = 0;
    while (!done && wait_cycles < 20000) begin
      if (poke && wait_cycles == 3) begin
        srcAddr = 16'(d); dstAddr = 16'(s); byteLen = 16'(n / 2 + 1); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      wait_cycles++;
    end
    start = 1'b0;
    check(done == 1'b1, "R7", "done seen before watchdog", int'(done), 1);
    if (n == 0) check(wait_cycles == 1, "R1", "zero-length done delay", wait_cycles + 1, 2);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "done one cycle then idle", int'(done), 0);
    repeat (6) @(negedge clk);
    check(doneCount - doneBefore == 1, poke ? "R8" : "R7", "done pulses", doneCount - doneBefore, 1);
    if (n == 0) check(opCount == 0, "R1", "accesses for zero length", opCount, 0);
    tag = wm ? "R3" : "R2";
    check(opCount == expCount, tag, "access count", opCount, expCount);
    firstBad = -1;
    for (int i = 0; i < expCount && i < opCount; i++)
      if (firstBad < 0 && (opW[i] != expW[i] || opA[i] != expA[i] || opBe[i] != expBe[i]))
        firstBad = i;
    check(firstBad < 0, tag, "access trace first mismatch index", firstBad, -1);
    wordWr = 0; byteWr = 0; expWordWr = 0; expByteWr = 0;
    for (int i = 0; i < opCount && i < MAXOPS; i++)
      if (opW[i]) begin if (opBe[i] == 4'b1111) wordWr++; else byteWr++; end
    if (wm) begin expWordWr = n / 4; expByteWr = n % 4; end
    else expByteWr = n;
    check(wordWr == expWordWr, "R4", "full-word writes", wordWr, expWordWr);
    check(byteWr == expByteWr, "R5", "byte writes", byteWr, expByteWr);
    mism = 0; firstBad = -1;
    for (int i = 0; i < MEM_BYTES; i++)
      if (mem[i] !== refMem[i]) begin mism++; if (firstBad < 0) firstBad = i; end
    check(mism == 0, poke ? "R8" : "R6", "memory byte mismatches", mism, 0);
    check(holdViol == 0, "R9", "request dropped before accept", holdViol, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && memValid == 0, "R7", "reset idle outputs",
          int'({busy, done, memValid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    runCase(0, 512, 0, 0);                       // R1
    runCase(64, 600, 16, 0);                     // R3 exact burst
    runCase(128, 700, 23, 0);                    // R3 R4 R5
    runCase(129, 700, 40, 0);                    // R2 misaligned source
    runCase(128, 702, 40, 0);                    // R2 misaligned destination
    runCase(200, 520, 12, 0);                    // R2 aligned but short
    runCase(16, 800, 60, 1);                     // R8 start while busy
    for (int n = 0; n <= 20; n++)
      runCase($urandom_range(0, 100), 512 + $urandom_range(0, 100), n, 0);
    for (int t = 0; t < 30; t++) begin
      int s, d;
      s = $urandom_range(0, 200); d = 512 + $urandom_range(0, 200);
      if ($urandom_range(1) == 1) begin s = s & ~3; d = d & ~3; end
      runCase(s, d, $urandom_range(0, 120), 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule